// File: doc/BRIEF.md
# Six-Stage Pipeline Stall Controller

This block tracks which slots of a six-stage in-order instruction pipeline hold live instructions. Each cycle it decides, for every stage, whether the stage loads from its predecessor, keeps its contents, takes a bubble, or is squashed. The stages, from youngest to oldest, are: opcode fetch (index 0), decode with operand prefetch (1), effective-address calculation (2), operand and register read (3), execute (4), and register writeback (5). A small tag travels with each instruction so that the surrounding datapath and a bench can follow it through the slots.

One memory bus is shared by the stages. Stage 0 asks for it whenever the fetch unit wants a new opcode. Any later stage asks for it through its own request bit. The oldest requester is granted the bus. When that is not the fetch stage, the younger stages freeze and one bubble enters the pipeline. A taken branch reported by the execute stage squashes every younger slot, and fetching restarts on the following cycle.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, every `stg_valid` bit is 0. With `fetch_req` low, `bus_gnt` is 0.
- R2: For straight-line code with no bus requests from stages 1 to 5, one instruction retires per cycle. The first instruction is on `retire` exactly 6 cycles after the cycle in which `bus_gnt[0]` fetched it.
- R3: The request of stage 0 is `fetch_req`. The request of stage i (i ≥ 1) is `bus_req[i]` when stage i is valid. Outside a flush, `bus_gnt` is one-hot on the highest-index requester, and it is zero when nothing requests.
- R4: When stage w ≥ 1 wins the bus, the following happens in that cycle. Stages above w advance. Stage w is flagged in `stg_bubble` and is invalid on the next cycle. Stages below w are flagged in `stg_hold` and keep their valid bit and tag. No opcode is fetched. As a result, the instruction after a bus-using instruction retires 2 cycles after it.
- R5: In every cycle each stage is in exactly one of the states advance, hold, bubble or squash. Every instruction visits every stage, including the address stage when it needs no address, and instructions retire in program order carrying their fetch tag.
- R6: When `br_taken` is high and stage 4 is valid, `flush` is high. On the next cycle stages 0 to 4 are invalid and the branch is valid in stage 5.
- R7: A flush has priority over a bus conflict. In a flush cycle `bus_gnt` and `stg_bubble` are zero, even when a squashed stage requests the bus.
- R8: Fetch may restart on the cycle after a flush. The first instruction at the branch target retires 6 cycles after the branch retires.
- R9: `bus_req[i]` for an invalid stage i is ignored, and so is `br_taken` while stage 4 is invalid. Neither produces a grant, a bubble or a flush.
- R10: When stage 1 and stage 3 request in the same cycle, stage 3 is served first and stage 1 on the next cycle. Each costs one bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch unit wants the bus for a new opcode |
| fetch_tag | input | TAG_W | Tag of the opcode being fetched |
| bus_req | input | NSTG | Per-stage bus request (bit 0 unused) |
| br_taken | input | 1 | Execute stage writes the instruction pointer |
| stg_valid | output | NSTG | Occupancy of each stage |
| stg_tags | output | NSTG*TAG_W | Tag held by each stage, stage i at bits i*TAG_W |
| stg_adv | output | NSTG | Stage loads from its predecessor this cycle |
| stg_hold | output | NSTG | Stage keeps its contents this cycle |
| stg_bubble | output | NSTG | Stage is emptied by a bus stall this cycle |
| stg_squash | output | NSTG | Stage is emptied by a flush this cycle |
| flush | output | 1 | Branch flush of stages 0 to 4 |
| bus_gnt | output | NSTG | One-hot bus grant |
| retire | output | 1 | Writeback stage holds a valid instruction |
| retire_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The grant, flush and stage-state outputs are combinational on the current occupancy, so they are compared in the same cycle as the requests that cause them. Occupancy changes are checked one cycle later. Completion timing is checked through the spacing between retirements. The scoreboard holds each expected tag with its expected gap in cycles: 6 after the first fetch grant or after a branch retires, and otherwise 1 plus one cycle for each bus use by the previous instruction. All outputs are sampled on the falling edge, and the gap is taken from a cycle counter that advances on the rising edge.

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
  parameter int NSTG   = 6,
  parameter int TAG_W  = 8,
  parameter int BR_STG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_req,
  input  logic [TAG_W-1:0]        fetch_tag,
  input  logic [NSTG-1:0]         bus_req,
  input  logic                    br_taken,
  output logic [NSTG-1:0]         stg_valid,
  output logic [NSTG*TAG_W-1:0]   stg_tags,
  output logic [NSTG-1:0]         stg_adv,
  output logic [NSTG-1:0]         stg_hold,
  output logic [NSTG-1:0]         stg_bubble,
  output logic [NSTG-1:0]         stg_squash,
  output logic                    flush,
  output logic [NSTG-1:0]         bus_gnt,
  output logic                    retire,
  output logic [TAG_W-1:0]        retire_tag
);
  localparam int WIN_W = $clog2(NSTG);

  logic [NSTG-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [NSTG];
  logic [NSTG-1:0]  req;
  logic [WIN_W-1:0] win;
  logic             any, stall;

  assign req   = {bus_req[NSTG-1:1] & vld_q[NSTG-1:1], fetch_req};
  assign flush = br_taken & vld_q[BR_STG];

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = 0; i < NSTG; i++)
      if (req[i]) begin
        win = WIN_W'(i);
        any = 1'b1;
      end
  end

  assign stall   = any && (win != '0) && !flush;
  assign bus_gnt = (flush || !any) ? '0 : (NSTG'(1) << win);

  always_comb begin
    for (int i = 0; i < NSTG; i++) begin
      stg_adv[i]    = 1'b0;
      stg_hold[i]   = 1'b0;
      stg_bubble[i] = 1'b0;
      stg_squash[i] = 1'b0;
      if (flush) begin
        if (i <= BR_STG) stg_squash[i] = 1'b1;
        else             stg_adv[i]    = 1'b1;
      end else if (stall) begin
        if (i > int'(win))       stg_adv[i]    = 1'b1;
        else if (i == int'(win)) stg_bubble[i] = 1'b1;
        else                     stg_hold[i]   = 1'b1;
      end else begin
        stg_adv[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSTG; i++) tag_q[i] <= '0;
    end else begin
      if (stg_squash[0] || stg_bubble[0]) vld_q[0] <= 1'b0;
      else if (stg_adv[0]) begin
        vld_q[0] <= bus_gnt[0];
        tag_q[0] <= fetch_tag;
      end
      for (int i = 1; i < NSTG; i++) begin
        if (stg_squash[i] || stg_bubble[i]) vld_q[i] <= 1'b0;
        else if (stg_adv[i]) begin
          vld_q[i] <= vld_q[i-1];
          tag_q[i] <= tag_q[i-1];
        end
      end
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_tag
    assign stg_tags[g*TAG_W +: TAG_W] = tag_q[g];
  end

  assign stg_valid  = vld_q;
  assign retire     = vld_q[NSTG-1];
  assign retire_tag = tag_q[NSTG-1];
endmodule

// File: rtl/pipe_stall_ctrl_chk.sv
module pipe_stall_ctrl_chk #(
  parameter int NSTG   = 6,
  parameter int TAG_W  = 8,
  parameter int BR_STG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSTG-1:0] stg_valid,
  input logic [NSTG-1:0] stg_adv,
  input logic [NSTG-1:0] stg_hold,
  input logic [NSTG-1:0] stg_bubble,
  input logic [NSTG-1:0] stg_squash,
  input logic            flush,
  input logic [NSTG-1:0] bus_gnt,
  input logic            retire
);
  localparam logic [NSTG-1:0] LOW_MASK = NSTG'((1 << (BR_STG + 1)) - 1);

  p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  p_gnt_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt[NSTG-1:1] & ~stg_valid[NSTG-1:1]) == '0);

  p_bubble_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_bubble != '0) |=> ((stg_valid & $past(stg_bubble)) == '0));

  p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_hold != '0) |=> ((stg_valid & $past(stg_hold)) == ($past(stg_valid) & $past(stg_hold))));

  p_state_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stg_adv | stg_hold | stg_bubble | stg_squash) == '1) &&
    ((stg_adv & (stg_hold | stg_bubble | stg_squash)) == '0) &&
    ((stg_hold & (stg_bubble | stg_squash)) == '0) &&
    ((stg_bubble & stg_squash) == '0));

  p_retire_from_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(stg_valid[NSTG-2]));

  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((stg_valid & LOW_MASK) == '0) && stg_valid[BR_STG+1]);

  p_flush_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (bus_gnt == '0) && (stg_bubble == '0));
endmodule

bind pipe_stall_ctrl pipe_stall_ctrl_chk #(.NSTG(NSTG), .TAG_W(TAG_W), .BR_STG(BR_STG)) u_chk (.*);

// File: tb/sim_pipe_stall_ctrl.sv
module sim_pipe_stall_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSTG = 6;
  localparam int TAG_W = 8;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_req, br_taken;
  logic [TAG_W-1:0] fetch_tag;
  logic [NSTG-1:0] bus_req, stg_valid, stg_adv, stg_hold, stg_bubble, stg_squash, bus_gnt;
  logic [NSTG*TAG_W-1:0] stg_tags;
  logic flush, retire;
  logic [TAG_W-1:0] retire_tag;

  pipe_stall_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit p_mem [256], p_long [256], p_jmp [256];
  int p_tgt [256];
  int plen = 0, pc = 0, pc_nxt = 0, cyc = 0, last = 0;
  bit run = 0, armed = 0, force_br = 0, flush_seen = 0;
  logic [NSTG-1:0] force_req = '0;
  int nchk = 0, nerr = 0, rcount = 0, bcount = 0;
  int exp_tag [$], exp_gap [$];

  function automatic int tag_of(int s);
    return int'(stg_tags[s*TAG_W +: TAG_W]);
  endfunction

  assign fetch_req = run && (pc < plen);
  assign fetch_tag = TAG_W'(pc);
  always_comb begin
    bus_req = force_req & {{(NSTG-1){1'b1}}, 1'b0};
    if (stg_valid[3] && p_mem[tag_of(3)])  bus_req[3] = 1'b1;
    if (stg_valid[1] && p_long[tag_of(1)]) bus_req[1] = 1'b1;
    br_taken = force_br || (stg_valid[4] && p_jmp[tag_of(4)]);
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pc  <= pc_nxt;
    if (cyc > WD_LIMIT) begin
      chk(0, "R2", "watchdog expired", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (flush) pc_nxt = p_tgt[tag_of(4)];
      else if (bus_gnt[0]) pc_nxt = pc + 1;
      else pc_nxt = pc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int w;
      logic [NSTG-1:0] eg;
      if (retire) begin
        if (exp_tag.size() == 0) chk(0, "R5", "unexpected retire tag", int'(retire_tag), -1);
        else begin
          int et, eg2;
          et = exp_tag.pop_front();
          eg2 = exp_gap.pop_front();
          chk(int'(retire_tag) == et, "R5", "retire order tag", int'(retire_tag), et);
          chk(cyc - last == eg2, eg2 == 6 ? "R8" : (eg2 == 1 ? "R2" : "R4"),
              "retire gap", cyc - last, eg2);
        end
        last = cyc;
        rcount++;
      end
      if (armed && bus_gnt[0]) begin
        last = cyc;
        armed = 0;
      end
      if (stg_bubble != '0) bcount++;
      w = -1;
      for (int i = 1; i < NSTG; i++) if (bus_req[i] && stg_valid[i]) w = i;
      if (w < 0 && fetch_req) w = 0;
      eg = (flush || w < 0) ? '0 : NSTG'(1) << w;
      chk(bus_gnt == eg, flush ? "R7" : "R3", "bus grant", int'(bus_gnt), int'(eg));
      if (flush_seen) begin
        chk(stg_valid[4:0] == '0, "R6", "valid after flush", int'(stg_valid), 0);
        chk(stg_valid[5], "R6", "branch in writeback", int'(stg_valid[5]), 1);
      end
      flush_seen = flush;
      if (flush) chk(stg_bubble == '0, "R7", "bubble during flush", int'(stg_bubble), 0);
    end
  end

  task automatic do_reset();
    rst_n = 0; run = 0; force_req = '0; force_br = 0; pc_nxt = 0;
    exp_tag.delete(); exp_gap.delete();
    repeat (3) @(negedge clk);
    chk(stg_valid == '0, "R1", "valid in reset", int'(stg_valid), 0);
    chk(bus_gnt == '0, "R1", "grant in reset", int'(bus_gnt), 0);
    rst_n = 1; armed = 1; rcount = 0; bcount = 0; flush_seen = 0;
    @(negedge clk);
    chk(stg_valid == '0, "R1", "valid after reset", int'(stg_valid), 0);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin
      p_mem[i] = 0; p_long[i] = 0; p_jmp[i] = 0; p_tgt[i] = 0;
    end
  endtask

  task automatic run_prog(string name, string req);
    int i, prev, n, ebub, t;
    do_reset();
    i = 0; prev = -1; n = 0; ebub = 0;
    while (i < plen && n < 200) begin
      exp_tag.push_back(i);
      if (prev < 0 || p_jmp[prev]) exp_gap.push_back(6);
      else exp_gap.push_back(1 + int'(p_mem[prev]) + int'(p_long[prev]));
      ebub += int'(p_mem[i]) + int'(p_long[i]);
      prev = i; n++;
      i = p_jmp[i] ? p_tgt[i] : i + 1;
    end
    run = 1;
    t = 0;
    while (exp_tag.size() > 0 && t < 400) begin @(negedge clk); t++; end
    chk(exp_tag.size() == 0, req, {name, " pending retires"}, exp_tag.size(), 0);
    repeat (10) @(negedge clk);
    chk(rcount == n, req, {name, " retire count"}, rcount, n);
    chk(bcount == ebub, req, {name, " bubble count"}, bcount, ebub);
    run = 0;
  endtask

  initial begin
    fork
      begin
        // R1, R9: invalid-stage requests and branch are ignored
        do_reset();
        force_req = '1; force_br = 1;
        @(negedge clk);
        chk(!flush, "R9", "flush with empty exec stage", int'(flush), 0);
        chk(bus_gnt == '0, "R9", "grant to empty stages", int'(bus_gnt), 0);
        chk(stg_bubble == '0, "R9", "bubble from empty stages", int'(stg_bubble), 0);
        @(negedge clk);
        chk(stg_valid == '0, "R9", "occupancy after ignored inputs", int'(stg_valid), 0);
        force_req = '0; force_br = 0;

        // R2, R5: straight-line code
        clear_prog(); plen = 8;
        run_prog("straight", "R2");

        // R4: memory operand reads at stage 3
        clear_prog(); plen = 10;
        p_mem[2] = 1; p_mem[3] = 1; p_mem[6] = 1;
        run_prog("mem conflicts", "R4");

        // R4: operand prefetch at stage 1
        clear_prog(); plen = 8;
        p_long[1] = 1; p_long[4] = 1; p_long[5] = 1;
        run_prog("operand prefetch", "R4");

        // R10: stage 3 and stage 1 request together
        clear_prog(); plen = 8;
        p_mem[2] = 1; p_long[4] = 1;
        run_prog("stacked conflict", "R10");

        // R6, R7, R8: branch flush with a squashed memory instruction behind it
        clear_prog(); plen = 10;
        p_jmp[2] = 1; p_tgt[2] = 7; p_mem[3] = 1; p_long[5] = 1;
        run_prog("branch", "R8");

        // R8: branch right after a memory instruction
        clear_prog(); plen = 12;
        p_mem[1] = 1; p_jmp[2] = 1; p_tgt[2] = 5; p_jmp[6] = 1; p_tgt[6] = 9;
        run_prog("two branches", "R8");
      end
    join
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule